// File: doc/BRIEF.md
# Lifecycle Transition Sequencer

This block steps a device through a change of its lifecycle state. After reset it waits in an idle state. When a transition request arrives it latches the target lifecycle code. It then selects the transition clock and checks that the transition counter can still be incremented. Next it asks for the counter to be written and checks that the target lies strictly above the current lifecycle code. It then asks for the unlock token digest and compares the digest against a reference in two halves. A target that needs a flash wipe inserts a wipe handshake before the comparison. Finally it asks for the new lifecycle code to be written. The storage, hash and flash engines sit outside the block and answer through simple request/done handshakes.

Every abort path ends in a single terminal post-transition state. On entry to that state the block pulses a completion strobe with an OK/error flag. Two independent escalation inputs each force a sticky escalate state. The state register uses a sparse 7-bit code in which any two legal states differ in at least three bits. Any other code falls through to an invalid state, or to the escalate state when an escalation input is active.

Top module: `life_xition_seq`

## Requirements
- R1: The state code on `fsmState` is one of: Reset 0x0E, Idle 0x15, ClkMux 0x1B, CntIncr 0x23, CntProg 0x2D, TransCheck 0x36, TokenHash 0x38, FlashRma 0x47, TokenCheck0 0x49, TokenCheck1 0x52, TransProg 0x5C, PostTrans 0x64, Scrap 0x6A, Escalate 0x71, Invalid 0x7F. Any two of these codes differ in at least 3 bits.
- R2: While `rstN` is low the state is Reset. On the first clock edge after release it moves to Idle, and Idle holds while no request is present.
- R3: A request in Idle walks the block through ClkMux, then CntIncr, then CntProg, one state per cycle. `clkSel` is high in every state from ClkMux through TransProg and low elsewhere. In CntProg, `cntProgReq` is high and `cntProgVal` equals `cntIn`+1.
- R4: In CntIncr, a counter value of all ones sends the block to PostTrans with an error completion.
- R5: A programming response with the error flag set, in CntProg or in TransProg, sends the block to PostTrans with an error completion.
- R6: In TransCheck the block moves to TokenHash only when the latched target is numerically greater than `curLc`. Otherwise it moves to PostTrans with an error.
- R7: TokenHash holds with `hashReq` high until `hashValid`. If the target equals RmaLc (default 9) the block then enters FlashRma, which holds `wipeReq` high until `wipeAck` and then enters TokenCheck0. Any other target goes straight to TokenCheck0.
- R8: TokenCheck0 compares the low half of the latched digest with `refDigest`, and TokenCheck1 compares the high half. A mismatch in either leads to PostTrans with an error. TokenCheck1 lasts exactly one cycle.
- R9: In TransProg, `stateProgVal` equals the latched target. A done response without error leads to PostTrans, with `doneValid` high for exactly one cycle, together with the first PostTrans cycle, and `doneOk` high.
- R10: CntProg, TokenHash and TransProg each give up after TimeoutCycles cycles without a response and move to PostTrans with an error.
- R11: In Idle, when `curLc` equals ScrapLc (default 15), the block enters Scrap even if a request is present.
- R12: Either escalation input alone moves the block to Escalate on the next edge from any state except Scrap, with no completion pulse.
- R13: PostTrans, Scrap and Escalate hold until reset and ignore requests. Escalate holds after the escalation inputs drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Transition request, sampled in Idle |
| reqTarget | input | LcW | Requested lifecycle code |
| curLc | input | LcW | Current lifecycle code |
| escA | input | 1 | Escalation input A |
| escB | input | 1 | Escalation input B |
| cntIn | input | CntW | Current transition counter value |
| cntProgDone | input | 1 | Counter write finished |
| cntProgErr | input | 1 | Counter write failed (valid with done) |
| hashValid | input | 1 | Token digest available |
| hashDigest | input | TokW | Token digest |
| refDigest | input | TokW | Reference digest for the comparison |
| wipeAck | input | 1 | Flash wipe finished |
| stateProgDone | input | 1 | Lifecycle write finished |
| stateProgErr | input | 1 | Lifecycle write failed (valid with done) |
| fsmState | output | 7 | Sparse state code |
| clkSel | output | 1 | Transition clock select |
| cntProgReq | output | 1 | Counter write request |
| cntProgVal | output | CntW | Counter value to write |
| hashReq | output | 1 | Token digest request |
| wipeReq | output | 1 | Flash wipe request |
| stateProgReq | output | 1 | Lifecycle write request |
| stateProgVal | output | LcW | Lifecycle code to write |
| doneValid | output | 1 | One-cycle completion strobe |
| doneOk | output | 1 | Completion status, high for success |

## Verification
The assertions assume that all inputs are synchronous to `clk`. They also assume that escalation, request and response inputs are free of X once reset is released. The properties on the Idle and Reset exits assume the escalation inputs are low, because escalation outranks every other exit. The bench changes inputs only on the falling clock edge. It drives each engine response as a single-cycle pulse, and only while the matching request output is high. This keeps every response in the cycle where the sequencer is waiting for it.

// File: rtl/life_xition_pkg.sv
package life_xition_pkg;

  // Codewords of a distance-3 linear code; any single flip lands off the legal set.
  typedef enum logic [6:0] {
    StReset       = 7'h0E,
    StIdle        = 7'h15,
    StClkMux      = 7'h1B,
    StCntIncr     = 7'h23,
    StCntProg     = 7'h2D,
    StTransCheck  = 7'h36,
    StTokenHash   = 7'h38,
    StFlashRma    = 7'h47,
    StTokenCheck0 = 7'h49,
    StTokenCheck1 = 7'h52,
    StTransProg   = 7'h5C,
    StPostTrans   = 7'h64,
    StScrap       = 7'h6A,
    StEscalate    = 7'h71,
    StInvalid     = 7'h7F
  } seqState_e;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic latchReq;
    logic latchDigest;
    logic timerRun;
  } ctrlStrobe_t;

  // Datapath-to-control decisions.
  typedef struct packed {
    logic targetLegal;
    logic lowMatch;
    logic highMatch;
    logic cntAtMax;
    logic waitExpired;
    logic rmaTarget;
  } dpFlag_t;

endpackage

// File: rtl/life_xition_dp.sv
module life_xition_dp
  import life_xition_pkg::*;
#(
  parameter int LcW           = 4,
  parameter int CntW          = 8,
  parameter int TokW          = 16,
  parameter int TimeoutCycles = 64,
  parameter int RmaLc         = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [LcW-1:0]    reqTarget,
  input  logic [LcW-1:0]    curLc,
  input  logic [CntW-1:0]   cntIn,
  input  logic [TokW-1:0]   hashDigest,
  input  logic [TokW-1:0]   refDigest,
  output dpFlag_t           flags,
  output logic [CntW-1:0]   cntProgVal,
  output logic [LcW-1:0]    stateProgVal
);

  localparam int HalfW  = TokW / 2;
  localparam int TimerW = $clog2(TimeoutCycles + 1);

  logic [LcW-1:0]    targetQ;
  logic [TokW-1:0]   digestQ;
  logic [TimerW-1:0] timerQ;
  logic [1:0]        halfMatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= '0;
      digestQ <= '0;
      timerQ  <= '0;
    end else begin
      if (strobe.latchReq)    targetQ <= reqTarget;
      if (strobe.latchDigest) digestQ <= hashDigest;
      timerQ <= strobe.timerRun ? timerQ + TimerW'(1) : '0;
    end
  end

  // One comparator per token half; index 0 is checked first.
  for (genvar h = 0; h < 2; h++) begin : g_half
    assign halfMatch[h] = (digestQ[h*HalfW +: HalfW] == refDigest[h*HalfW +: HalfW]);
  end

  always_comb begin
    flags.targetLegal = (targetQ > curLc);
    flags.lowMatch    = halfMatch[0];
    flags.highMatch   = halfMatch[1];
    flags.cntAtMax    = &cntIn;
    flags.waitExpired = (timerQ == TimerW'(TimeoutCycles - 1));
    flags.rmaTarget   = (targetQ == LcW'(RmaLc));
  end

  assign cntProgVal   = cntIn + CntW'(1);
  assign stateProgVal = targetQ;

endmodule

// File: rtl/life_xition_ctrl.sv
module life_xition_ctrl
  import life_xition_pkg::*;
#(
  parameter int LcW     = 4,
  parameter int ScrapLc = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           reqValid,
  input  logic [LcW-1:0] curLc,
  input  logic           escA,
  input  logic           escB,
  input  logic           cntProgDone,
  input  logic           cntProgErr,
  input  logic           hashValid,
  input  logic           wipeAck,
  input  logic           stateProgDone,
  input  logic           stateProgErr,
  input  dpFlag_t        flags,
  output ctrlStrobe_t    strobe,
  output logic [6:0]     fsmState,
  output logic           clkSel,
  output logic           cntProgReq,
  output logic           hashReq,
  output logic           wipeReq,
  output logic           stateProgReq,
  output logic           doneValid,
  output logic           doneOk
);

  seqState_e stateQ, stateD;
  logic      fail, endOk, endErr;

  always_comb begin
    stateD = stateQ;
    fail   = 1'b0;
    endOk  = 1'b0;
    case (stateQ)
      StReset:      stateD = StIdle;
      StIdle: begin
        if (curLc == LcW'(ScrapLc)) stateD = StScrap;
        else if (reqValid)          stateD = StClkMux;
      end
      StClkMux:     stateD = StCntIncr;
      StCntIncr: begin
        if (flags.cntAtMax) fail = 1'b1;
        else                stateD = StCntProg;
      end
      StCntProg: begin
        if (cntProgDone) begin
          if (cntProgErr) fail = 1'b1;
          else            stateD = StTransCheck;
        end else if (flags.waitExpired) fail = 1'b1;
      end
      StTransCheck: begin
        if (flags.targetLegal) stateD = StTokenHash;
        else                   fail = 1'b1;
      end
      StTokenHash: begin
        if (hashValid)                  stateD = flags.rmaTarget ? StFlashRma : StTokenCheck0;
        else if (flags.waitExpired)     fail = 1'b1;
      end
      StFlashRma:   if (wipeAck) stateD = StTokenCheck0;
      StTokenCheck0: begin
        if (flags.lowMatch) stateD = StTokenCheck1;
        else                fail = 1'b1;
      end
      StTokenCheck1: begin
        if (flags.highMatch) stateD = StTransProg;
        else                 fail = 1'b1;
      end
      StTransProg: begin
        if (stateProgDone) begin
          if (stateProgErr) fail = 1'b1;
          else begin
            stateD = StPostTrans;
            endOk  = 1'b1;
          end
        end else if (flags.waitExpired) fail = 1'b1;
      end
      StPostTrans, StScrap, StEscalate, StInvalid: stateD = stateQ;
      default:      stateD = StInvalid;
    endcase
    endErr = fail;
    if (fail) stateD = StPostTrans;
    // Escalation outranks every exit; Scrap is the only state it leaves alone.
    if ((escA || escB) && stateQ != StScrap) begin
      stateD = StEscalate;
      endErr = 1'b0;
      endOk  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= StReset;
      doneValid <= 1'b0;
      doneOk    <= 1'b0;
    end else begin
      stateQ    <= stateD;
      doneValid <= endOk | endErr;
      doneOk    <= endOk;
    end
  end

  always_comb begin
    strobe.latchReq    = (stateQ == StIdle) && reqValid;
    strobe.latchDigest = (stateQ == StTokenHash) && hashValid;
    strobe.timerRun    = (stateQ inside {StCntProg, StTokenHash, StTransProg});
  end

  assign fsmState     = stateQ;
  assign clkSel       = stateQ inside {StClkMux, StCntIncr, StCntProg, StTransCheck, StTokenHash,
                                       StFlashRma, StTokenCheck0, StTokenCheck1, StTransProg};
  assign cntProgReq   = (stateQ == StCntProg);
  assign hashReq      = (stateQ == StTokenHash);
  assign wipeReq      = (stateQ == StFlashRma);
  assign stateProgReq = (stateQ == StTransProg);

endmodule

// File: rtl/life_xition_seq.sv
module life_xition_seq
  import life_xition_pkg::*;
#(
  parameter int LcW           = 4,
  parameter int CntW          = 8,
  parameter int TokW          = 16,
  parameter int TimeoutCycles = 64,
  parameter int RmaLc         = 9,
  parameter int ScrapLc       = 15
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            reqValid,
  input  logic [LcW-1:0]  reqTarget,
  input  logic [LcW-1:0]  curLc,
  input  logic            escA,
  input  logic            escB,
  input  logic [CntW-1:0] cntIn,
  input  logic            cntProgDone,
  input  logic            cntProgErr,
  input  logic            hashValid,
  input  logic [TokW-1:0] hashDigest,
  input  logic [TokW-1:0] refDigest,
  input  logic            wipeAck,
  input  logic            stateProgDone,
  input  logic            stateProgErr,
  output logic [6:0]      fsmState,
  output logic            clkSel,
  output logic            cntProgReq,
  output logic [CntW-1:0] cntProgVal,
  output logic            hashReq,
  output logic            wipeReq,
  output logic            stateProgReq,
  output logic [LcW-1:0]  stateProgVal,
  output logic            doneValid,
  output logic            doneOk
);

  ctrlStrobe_t strobe;
  dpFlag_t     flags;

  life_xition_ctrl #(
    .LcW     (LcW),
    .ScrapLc (ScrapLc)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .reqValid      (reqValid),
    .curLc         (curLc),
    .escA          (escA),
    .escB          (escB),
    .cntProgDone   (cntProgDone),
    .cntProgErr    (cntProgErr),
    .hashValid     (hashValid),
    .wipeAck       (wipeAck),
    .stateProgDone (stateProgDone),
    .stateProgErr  (stateProgErr),
    .flags         (flags),
    .strobe        (strobe),
    .fsmState      (fsmState),
    .clkSel        (clkSel),
    .cntProgReq    (cntProgReq),
    .hashReq       (hashReq),
    .wipeReq       (wipeReq),
    .stateProgReq  (stateProgReq),
    .doneValid     (doneValid),
    .doneOk        (doneOk)
  );

  life_xition_dp #(
    .LcW           (LcW),
    .CntW          (CntW),
    .TokW          (TokW),
    .TimeoutCycles (TimeoutCycles),
    .RmaLc         (RmaLc)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqTarget    (reqTarget),
    .curLc        (curLc),
    .cntIn        (cntIn),
    .hashDigest   (hashDigest),
    .refDigest    (refDigest),
    .flags        (flags),
    .cntProgVal   (cntProgVal),
    .stateProgVal (stateProgVal)
  );

endmodule

// File: rtl/life_xition_chk.sv
module life_xition_chk
  import life_xition_pkg::*;
#(
  parameter int LcW     = 4,
  parameter int ScrapLc = 15
) (
  input logic           clk,
  input logic           rstN,
  input logic           reqValid,
  input logic [LcW-1:0] curLc,
  input logic           escA,
  input logic           escB,
  input logic [6:0]     fsmState,
  input logic           cntProgReq,
  input logic           hashReq,
  input logic           wipeReq,
  input logic           stateProgReq,
  input logic           doneValid,
  input logic           doneOk
);

  // R12
  esc_to_escalate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((escA || escB) && fsmState != StScrap) |=> fsmState == StEscalate);

  // R13
  escalate_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsmState == StEscalate |=> fsmState == StEscalate);

  // R13
  posttrans_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsmState == StPostTrans |=> (fsmState == StPostTrans || fsmState == StEscalate));

  // R13
  scrap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsmState == StScrap |=> fsmState == StScrap);

  // R8
  tokcheck1_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    fsmState == StTokenCheck1 |=> fsmState != StTokenCheck1);

  // R9
  done_in_posttrans_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> fsmState == StPostTrans);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R9
  ok_needs_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneOk |-> doneValid);

  // R3
  req_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({cntProgReq, hashReq, wipeReq, stateProgReq}));

  // R11
  scrap_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsmState == StIdle && curLc == LcW'(ScrapLc) && !escA && !escB) |=> fsmState == StScrap);

  // R3
  idle_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsmState == StIdle && reqValid && curLc != LcW'(ScrapLc) && !escA && !escB)
      |=> fsmState == StClkMux);

  // R2
  reset_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fsmState == StReset && !escA && !escB) |=> fsmState == StIdle);

endmodule

bind life_xition_seq life_xition_chk #(
  .LcW     (LcW),
  .ScrapLc (ScrapLc)
) u_life_xition_chk (
  .clk          (clk),
  .rstN         (rstN),
  .reqValid     (reqValid),
  .curLc        (curLc),
  .escA         (escA),
  .escB         (escB),
  .fsmState     (fsmState),
  .cntProgReq   (cntProgReq),
  .hashReq      (hashReq),
  .wipeReq      (wipeReq),
  .stateProgReq (stateProgReq),
  .doneValid    (doneValid),
  .doneOk       (doneOk)
);

// File: tb/test_life_xition_seq.sv
module test_life_xition_seq;

  localparam int LcW = 4;
  localparam int CntW = 8;
  localparam int TokW = 16;
  localparam int TimeoutCycles = 16;
  localparam logic [TokW-1:0] RefTok = 16'hA55A;

  localparam logic [6:0] S_RESET = 7'h0E, S_IDLE = 7'h15, S_CLKMUX = 7'h1B,
    S_CNTINCR = 7'h23, S_CNTPROG = 7'h2D, S_TRANSCHECK = 7'h36, S_TOKENHASH = 7'h38,
    S_FLASHRMA = 7'h47, S_TOKCHK0 = 7'h49, S_TOKCHK1 = 7'h52, S_TRANSPROG = 7'h5C,
    S_POSTTRANS = 7'h64, S_SCRAP = 7'h6A, S_ESCALATE = 7'h71;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [LcW-1:0] reqTarget = '0, curLc = '0;
  logic escA = 1'b0, escB = 1'b0;
  logic [CntW-1:0] cntIn = '0;
  logic cntProgDone = 1'b0, cntProgErr = 1'b0, hashValid = 1'b0, wipeAck = 1'b0;
  logic stateProgDone = 1'b0, stateProgErr = 1'b0;
  logic [TokW-1:0] hashDigest = '0, refDigest = RefTok;
  logic [6:0] fsmState;
  logic clkSel, cntProgReq, hashReq, wipeReq, stateProgReq, doneValid, doneOk;
  logic [CntW-1:0] cntProgVal;
  logic [LcW-1:0] stateProgVal;

  int nChecks = 0;
  int nFail = 0;
  logic [6:0] seen [0:31];
  int nSeen = 0;

  always #2 clk = ~clk;

  life_xition_seq #(
    .LcW(LcW), .CntW(CntW), .TokW(TokW), .TimeoutCycles(TimeoutCycles),
    .RmaLc(9), .ScrapLc(15)
  ) i_life_xition_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTarget(reqTarget), .curLc(curLc),
    .escA(escA), .escB(escB), .cntIn(cntIn), .cntProgDone(cntProgDone),
    .cntProgErr(cntProgErr), .hashValid(hashValid), .hashDigest(hashDigest),
    .refDigest(refDigest), .wipeAck(wipeAck), .stateProgDone(stateProgDone),
    .stateProgErr(stateProgErr), .fsmState(fsmState), .clkSel(clkSel),
    .cntProgReq(cntProgReq), .cntProgVal(cntProgVal), .hashReq(hashReq),
    .wipeReq(wipeReq), .stateProgReq(stateProgReq), .stateProgVal(stateProgVal),
    .doneValid(doneValid), .doneOk(doneOk)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic noteCode(input logic [6:0] c);
    bit found = 1'b0;
    for (int i = 0; i < nSeen; i++) if (seen[i] == c) found = 1'b1;
    if (!found && nSeen < 32) begin
      seen[nSeen] = c;
      nSeen++;
    end
  endtask

  task automatic expState(input string tag, input logic [6:0] exp);
    chk(tag, fsmState, exp);
    noteCode(fsmState);
  endtask

  task automatic doReset();
    rstN = 1'b0; reqValid = 1'b0; escA = 1'b0; escB = 1'b0;
    cntProgDone = 1'b0; cntProgErr = 1'b0; hashValid = 1'b0; wipeAck = 1'b0;
    stateProgDone = 1'b0; stateProgErr = 1'b0;
    repeat (2) step();
    expState("R2 state in reset", S_RESET);
    rstN = 1'b1;
    step();
    expState("R2 idle after reset", S_IDLE);
  endtask

  task automatic finishErr(input string tag);
    expState({tag, " post-transition"}, S_POSTTRANS);
    chk({tag, " doneValid"}, doneValid, 1);
    chk({tag, " doneOk"}, doneOk, 0);
  endtask

  task automatic toCntIncr(input logic [LcW-1:0] tgt, input logic [LcW-1:0] cur,
                           input logic [CntW-1:0] cnt);
    doReset();
    reqTarget = tgt; curLc = cur; cntIn = cnt; reqValid = 1'b1;
    step();
    reqValid = 1'b0;
    expState("R3 clock mux", S_CLKMUX);
    chk("R3 clkSel in ClkMux", clkSel, 1);
    step();
    expState("R3 counter increment", S_CNTINCR);
  endtask

  task automatic toTokenHash(input logic [LcW-1:0] tgt, input logic [LcW-1:0] cur);
    toCntIncr(tgt, cur, 8'h10);
    step();
    expState("R3 counter program", S_CNTPROG);
    cntProgDone = 1'b1;
    step();
    cntProgDone = 1'b0;
    expState("R6 transition check", S_TRANSCHECK);
    step();
    expState("R6 legal target reaches TokenHash", S_TOKENHASH);
  endtask

  task automatic feedDigest(input logic [TokW-1:0] d);
    hashDigest = d; hashValid = 1'b1;
    step();
    hashValid = 1'b0;
  endtask

  task automatic tReset();
    doReset();
    chk("R2 clkSel low in Idle", clkSel, 0);
    chk("R2 no requests in Idle", {cntProgReq, hashReq, wipeReq, stateProgReq}, 0);
    chk("R2 doneValid low", doneValid, 0);
    repeat (3) step();
    expState("R2 Idle holds", S_IDLE);
  endtask

  task automatic tHappy(input logic [LcW-1:0] tgt, input bit rma);
    toCntIncr(tgt, 4'd2, 8'h41);
    step();
    expState("R3 counter program", S_CNTPROG);
    chk("R3 cntProgReq", cntProgReq, 1);
    chk("R3 cntProgVal", cntProgVal, 8'h42);
    cntProgDone = 1'b1;
    step();
    cntProgDone = 1'b0;
    expState("R6 transition check", S_TRANSCHECK);
    step();
    expState("R7 token hash", S_TOKENHASH);
    repeat (3) step();
    expState("R7 TokenHash waits for hashValid", S_TOKENHASH);
    chk("R7 hashReq", hashReq, 1);
    feedDigest(RefTok);
    if (rma) begin
      expState("R7 flash wipe", S_FLASHRMA);
      chk("R7 wipeReq", wipeReq, 1);
      step();
      expState("R7 FlashRma waits for wipeAck", S_FLASHRMA);
      wipeAck = 1'b1;
      step();
      wipeAck = 1'b0;
    end
    expState("R7 token check low", S_TOKCHK0);
    step();
    expState("R8 token check high", S_TOKCHK1);
    step();
    expState("R8 TokenCheck1 left after one cycle", S_TRANSPROG);
    chk("R9 stateProgReq", stateProgReq, 1);
    chk("R9 stateProgVal", stateProgVal, tgt);
    chk("R3 clkSel in TransProg", clkSel, 1);
    stateProgDone = 1'b1;
    step();
    stateProgDone = 1'b0;
    expState("R9 post-transition", S_POSTTRANS);
    chk("R9 doneValid", doneValid, 1);
    chk("R9 doneOk", doneOk, 1);
    chk("R3 clkSel low after", clkSel, 0);
    step();
    chk("R9 doneValid single cycle", doneValid, 0);
    expState("R13 PostTrans holds", S_POSTTRANS);
  endtask

  task automatic tCntMax();
    toCntIncr(4'd5, 4'd2, 8'hFF);
    step();
    finishErr("R4 counter at max");
    reqValid = 1'b1;
    repeat (3) step();
    reqValid = 1'b0;
    expState("R13 request ignored in PostTrans", S_POSTTRANS);
    chk("R13 no new completion", doneValid, 0);
  endtask

  task automatic tCntErr();
    toCntIncr(4'd5, 4'd2, 8'h03);
    step();
    expState("R5 counter program", S_CNTPROG);
    cntProgDone = 1'b1; cntProgErr = 1'b1;
    step();
    cntProgDone = 1'b0; cntProgErr = 1'b0;
    finishErr("R5 counter program error");
  endtask

  task automatic tIllegal(input logic [LcW-1:0] tgt, input logic [LcW-1:0] cur);
    toCntIncr(tgt, cur, 8'h03);
    step();
    cntProgDone = 1'b1;
    step();
    cntProgDone = 1'b0;
    expState("R6 transition check", S_TRANSCHECK);
    step();
    finishErr("R6 target not above current");
  endtask

  task automatic tTokLow();
    toTokenHash(4'd6, 4'd1);
    feedDigest(RefTok ^ 16'h0001);
    expState("R8 token check low", S_TOKCHK0);
    step();
    finishErr("R8 low half mismatch");
  endtask

  task automatic tTokHigh();
    toTokenHash(4'd6, 4'd1);
    feedDigest(RefTok ^ 16'h0100);
    expState("R8 token check low", S_TOKCHK0);
    step();
    expState("R8 low half matched", S_TOKCHK1);
    step();
    finishErr("R8 high half mismatch");
  endtask

  task automatic tTimeout();
    toTokenHash(4'd7, 4'd3);
    for (int i = 1; i < TimeoutCycles; i++) begin
      step();
      expState("R10 still waiting in TokenHash", S_TOKENHASH);
    end
    step();
    finishErr("R10 hash timeout");
  endtask

  task automatic tProgErr();
    toTokenHash(4'd8, 4'd3);
    feedDigest(RefTok);
    expState("R8 token check low", S_TOKCHK0);
    step();
    step();
    expState("R5 state program", S_TRANSPROG);
    chk("R9 stateProgVal", stateProgVal, 8);
    stateProgDone = 1'b1; stateProgErr = 1'b1;
    step();
    stateProgDone = 1'b0; stateProgErr = 1'b0;
    finishErr("R5 state program error");
  endtask

  task automatic tScrap();
    doReset();
    curLc = 4'd15; reqTarget = 4'd3; reqValid = 1'b1;
    step();
    expState("R11 scrap from Idle", S_SCRAP);
    chk("R11 clkSel stays low", clkSel, 0);
    escA = 1'b1;
    step();
    escA = 1'b0;
    expState("R12 escalation leaves Scrap alone", S_SCRAP);
    step();
    reqValid = 1'b0;
    expState("R13 Scrap holds", S_SCRAP);
    curLc = 4'd0;
  endtask

  task automatic tEscalate();
    toCntIncr(4'd5, 4'd2, 8'h03);
    step();
    expState("R12 counter program", S_CNTPROG);
    escA = 1'b1;
    step();
    escA = 1'b0;
    expState("R12 escalation A", S_ESCALATE);
    chk("R12 no completion on escalation", doneValid, 0);
    cntProgDone = 1'b1; reqValid = 1'b1;
    step();
    cntProgDone = 1'b0; reqValid = 1'b0;
    expState("R13 Escalate sticky", S_ESCALATE);
    doReset();
    escB = 1'b1;
    step();
    escB = 1'b0;
    expState("R12 escalation B from Idle", S_ESCALATE);
    toTokenHash(4'd6, 4'd1);
    feedDigest(RefTok ^ 16'h0010);
    step();
    finishErr("R12 setup");
    escB = 1'b1;
    step();
    escB = 1'b0;
    expState("R12 escalation from PostTrans", S_ESCALATE);
  endtask

  initial begin
    tReset();
    tHappy(4'd5, 1'b0);
    tHappy(4'd9, 1'b1);
    tCntMax();
    tCntErr();
    tIllegal(4'd2, 4'd2);
    tIllegal(4'd1, 4'd3);
    tTokLow();
    tTokHigh();
    tTimeout();
    tProgErr();
    tScrap();
    tEscalate();
    chk("R1 distinct state codes observed", nSeen, 14);
    for (int i = 0; i < nSeen; i++)
      for (int j = i + 1; j < nSeen; j++)
        chk("R1 pairwise distance at least 3", ($countones(seen[i] ^ seen[j]) >= 3), 1);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R2 watchdog: actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

endmodule